// File: doc/BRIEF.md
# Full-Duplex Synchronous Serial Port with Double-Buffered Receive

This block is a full-duplex synchronous serial port that can act as the clock master or as a clock-driven slave. A single shift register carries both directions. The transmit word goes out of its top bit, and received bits enter at its bottom bit. A separate receive buffer sits behind the shifter. It holds the last completed frame until the host reads it, so a second frame can be received while the first is still waiting.

The host side is a strobe-style register port. A write pulse loads the shifter, and in master mode it also starts a frame. The receive buffer is always visible on the read bus, and a read pulse marks it consumed. Three status flags report a frame in flight, a full buffer and a master-mode overrun. The configuration inputs select master or slave, 8- or 16-bit frames, the clock edge used to drive and the edge used to sample, the idle clock level, and the master clock divider. The serial pins are modelled as output, output-enable and input triples so that the pad logic can sit outside.

Top module: `mw_port`

## Requirements
- R1: A synchronous reset clears `busy`, `rbf`, `ovr` and `rd_data` to 0. It also puts `sclk_out` at the `cfg_idle_hi` level.
- R2: In a 16-bit frame (`cfg_wide`=1) the word on the sending line leaves most significant bit first. In the same frame, the 16 bits taken from the receiving line become the buffer word, first bit received in bit 15.
- R3: In an 8-bit frame (`cfg_wide`=0) only bits 7..0 of the shifter take part. The received byte lands in buffer bits 7..0, and buffer bits 15..8 keep their previous value.
- R4: With `cfg_alt`=0, data changes after falling clock edges and is sampled on rising edges. With `cfg_alt`=1 the two edges swap roles. Both hold for either idle level.
- R5: As master, each clock half-period lasts `cfg_div`+1 system clocks. A frame makes exactly 2·N clock edges, where N is 8 or 16.
- R6: A host write loads the shifter and leaves `rd_data` unchanged.
- R7: A completed frame enters the buffer and sets `rbf` only while `rbf` is 0. Otherwise it waits in the shifter, and the buffer and `rbf` hold. A read pulse clears `rbf`. The cycle after that, a waiting frame moves into the buffer and `rbf` is set again.
- R8: A master-mode write made while `rbf` is 1 and a frame is waiting sets `ovr`. `ovr` stays set until an `ovr_clr` pulse.
- R9: In slave mode the port drives `mi_out` (with `mi_oe` high while selected) and samples `mo_in` on edges of the synchronised `sclk_in`, but only while `sel_n` is low. A frame completes after N sampling edges, and `ovr` is never set.
- R10: As master, `busy` rises on the cycle after a write and falls with the last clock edge. While not busy, `sclk_out` rests at the idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1: generate the serial clock; 0: follow `sclk_in` |
| cfg_wide | input | 1 | 1: 16-bit frames; 0: 8-bit frames |
| cfg_alt | input | 1 | 0: drive on falling, sample on rising; 1: the reverse |
| cfg_idle_hi | input | 1 | Serial clock level between frames |
| cfg_div | input | DIV_W | Master half-period is `cfg_div`+1 system clocks |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | DATA_W | Word loaded into the shifter |
| rd_en | input | 1 | Host read strobe (consumes the buffer) |
| rd_data | output | DATA_W | Receive buffer contents |
| ovr_clr | input | 1 | Clears the overrun flag |
| busy | output | 1 | Frame in progress (master) or port selected (slave) |
| rbf | output | 1 | Receive buffer holds unread data |
| ovr | output | 1 | Sticky master overrun flag |
| sclk_out | output | 1 | Serial clock driven in master mode |
| sclk_oe | output | 1 | Enable for `sclk_out` |
| sclk_in | input | 1 | Serial clock received in slave mode |
| sel_n | input | 1 | Active-low slave select |
| mo_out | output | 1 | Master-side data line, driven in master mode |
| mo_oe | output | 1 | Enable for `mo_out` |
| mo_in | input | 1 | Master-side data line, sampled in slave mode |
| mi_out | output | 1 | Slave-side data line, driven in slave mode |
| mi_oe | output | 1 | Enable for `mi_out` |
| mi_in | input | 1 | Slave-side data line, sampled in master mode |

## Verification
The properties assume that the configuration inputs stay fixed while a frame is in flight and that the host never writes while `busy` is high. The bench changes the mode only between frames, after `busy` has dropped and a few idle cycles have passed, and it issues every write before raising the select. In slave runs the bench keeps each serial half-period at six system clocks. That is well above the synchroniser delay, so data sampled inside the port is always settled.

// File: rtl/mw_pkg.sv
package mw_pkg;
  // One-cycle strobes marking a serial clock transition in the system clock domain.
  typedef struct packed {
    logic rise;
    logic fall;
  } mw_edge_t;
endpackage

// File: rtl/mw_clkgen.sv
module mw_clkgen #(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             wide,
  input  logic             idle_hi,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             running,
  output mw_pkg::mw_edge_t edg_o
);
  localparam int HALF   = DATA_W / 2;
  localparam int EDGE_W = $clog2(2 * DATA_W + 1);

  logic [DIV_W-1:0]  cnt;
  logic [EDGE_W-1:0] edges;
  logic [EDGE_W-1:0] last;
  logic              tick;

  assign last       = wide ? EDGE_W'(2 * DATA_W - 1) : EDGE_W'(2 * HALF - 1);
  assign tick       = running && (cnt == div);
  assign edg_o.rise = tick & ~sclk;
  assign edg_o.fall = tick & sclk;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
      edges   <= '0;
      sclk    <= idle_hi;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= '0;
      edges   <= '0;
    end else if (running) begin
      if (tick) begin
        cnt   <= '0;
        sclk  <= ~sclk;
        edges <= edges + EDGE_W'(1);
        if (edges == last) running <= 1'b0;
      end else begin
        cnt <= cnt + DIV_W'(1);
      end
    end else begin
      sclk <= idle_hi;
    end
  end
endmodule

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_in,
  input  logic             sel_n,
  output logic             sel,
  output mw_pkg::mw_edge_t edg_o
);
  logic [STAGES-1:0] clk_s;
  logic [STAGES-1:0] sel_s;
  logic              clk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_s    <= '0;
      sel_s    <= '1;
      clk_prev <= 1'b0;
    end else begin
      clk_s    <= {clk_s[STAGES-2:0], sclk_in};
      sel_s    <= {sel_s[STAGES-2:0], sel_n};
      clk_prev <= clk_s[STAGES-1];
    end
  end

  assign sel        = ~sel_s[STAGES-1];
  assign edg_o.rise = sel & clk_s[STAGES-1] & ~clk_prev;
  assign edg_o.fall = sel & ~clk_s[STAGES-1] & clk_prev;
endmodule

// File: rtl/mw_rxbuf.sv
module mw_rxbuf #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic              wide,
  input  logic [DATA_W-1:0] shift_q,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              ovr_chk,
  input  logic              ovr_clr,
  output logic [DATA_W-1:0] rbuf,
  output logic              rbf,
  output logic              ovr
);
  localparam int HALF = DATA_W / 2;

  logic pending;
  logic move;

  assign move = pending && !rbf;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      rbf     <= 1'b0;
      ovr     <= 1'b0;
      rbuf    <= '0;
    end else begin
      if (done) pending <= 1'b1;
      else if (wr_en || move) pending <= 1'b0;

      if (move) begin
        rbf <= 1'b1;
        if (wide) rbuf <= shift_q;
        else rbuf[HALF-1:0] <= shift_q[HALF-1:0];
      end else if (rd_en) begin
        rbf <= 1'b0;
      end

      if (ovr_chk && rbf && pending) ovr <= 1'b1;
      else if (ovr_clr) ovr <= 1'b0;
    end
  end
endmodule

// File: rtl/mw_port.sv
module mw_port #(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_master,
  input  logic              cfg_wide,
  input  logic              cfg_alt,
  input  logic              cfg_idle_hi,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ovr_clr,
  output logic              busy,
  output logic              rbf,
  output logic              ovr,
  output logic              sclk_out,
  output logic              sclk_oe,
  input  logic              sclk_in,
  input  logic              sel_n,
  output logic              mo_out,
  output logic              mo_oe,
  input  logic              mo_in,
  output logic              mi_out,
  output logic              mi_oe,
  input  logic              mi_in
);
  localparam int HALF  = DATA_W / 2;
  localparam int CNT_W = $clog2(DATA_W + 1);

  mw_pkg::mw_edge_t m_edg, s_edg, edg;
  logic              running, sclk_m, sel;
  logic [DATA_W-1:0] sh;
  logic              dout_q;
  logic [CNT_W-1:0]  bitcnt, frame_len;
  logic              sample_ev, drive_ev, sample_ok, done, din, msb, m_start;

  assign m_start = cfg_master & wr_en;

  mw_clkgen #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst(rst), .start(m_start), .wide(cfg_wide),
    .idle_hi(cfg_idle_hi), .div(cfg_div), .sclk(sclk_m),
    .running(running), .edg_o(m_edg)
  );

  mw_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .sclk_in(sclk_in), .sel_n(sel_n),
    .sel(sel), .edg_o(s_edg)
  );

  always_comb begin
    edg       = cfg_master ? m_edg : s_edg;
    sample_ev = cfg_alt ? edg.fall : edg.rise;
    drive_ev  = cfg_alt ? edg.rise : edg.fall;
    frame_len = cfg_wide ? CNT_W'(DATA_W) : CNT_W'(HALF);
    sample_ok = sample_ev && (bitcnt != frame_len);
    done      = sample_ok && (bitcnt == frame_len - CNT_W'(1));
    din       = cfg_master ? mi_in : mo_in;
    msb       = cfg_wide ? sh[DATA_W-1] : sh[HALF-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      dout_q <= 1'b0;
      bitcnt <= '0;
    end else if (wr_en) begin
      sh     <= wr_data;
      dout_q <= cfg_wide ? wr_data[DATA_W-1] : wr_data[HALF-1];
      bitcnt <= '0;
    end else begin
      if (!cfg_master && !sel) bitcnt <= '0;
      else if (sample_ok) bitcnt <= bitcnt + CNT_W'(1);
      if (sample_ok) begin
        if (cfg_wide) sh <= {sh[DATA_W-2:0], din};
        else sh[HALF-1:0] <= {sh[HALF-2:0], din};
      end
      if (drive_ev) dout_q <= msb;
    end
  end

  mw_rxbuf #(.DATA_W(DATA_W)) u_rxbuf (
    .clk(clk), .rst(rst), .done(done), .wide(cfg_wide), .shift_q(sh),
    .rd_en(rd_en), .wr_en(wr_en), .ovr_chk(m_start), .ovr_clr(ovr_clr),
    .rbuf(rd_data), .rbf(rbf), .ovr(ovr)
  );

  assign busy     = cfg_master ? running : sel;
  assign sclk_out = sclk_m;
  assign sclk_oe  = cfg_master;
  assign mo_out   = cfg_master & dout_q;
  assign mo_oe    = cfg_master;
  assign mi_out   = dout_q;
  assign mi_oe    = ~cfg_master & sel;
endmodule

// File: rtl/mw_port_chk.sv
module mw_port_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_master,
  input logic              cfg_idle_hi,
  input logic              wr_en,
  input logic              rd_en,
  input logic              ovr_clr,
  input logic [DATA_W-1:0] rd_data,
  input logic              busy,
  input logic              rbf,
  input logic              ovr,
  input logic              sclk_out
);
  a_r1_reset_flags: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !rbf && !ovr && rd_data == '0));

  a_r6_write_keeps_buf: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rbf) |=> $stable(rd_data));

  a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rbf) |=> !rbf);

  a_r7_full_holds: assert property (@(posedge clk) disable iff (rst)
    (rbf && !rd_en) |=> (rbf && $stable(rd_data)));

  a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovr && !ovr_clr) |=> ovr);

  a_r9_slave_no_ovr: assert property (@(posedge clk) disable iff (rst)
    (!cfg_master && !ovr) |=> !ovr);

  a_r10_idle_level: assert property (@(posedge clk) disable iff (rst)
    (cfg_master && !busy && $stable(cfg_idle_hi)) |-> (sclk_out == cfg_idle_hi));
endmodule

bind mw_port mw_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_idle_hi(cfg_idle_hi),
  .wr_en(wr_en), .rd_en(rd_en), .ovr_clr(ovr_clr), .rd_data(rd_data),
  .busy(busy), .rbf(rbf), .ovr(ovr), .sclk_out(sclk_out)
);

// File: tb/mw_port_test.sv
module mw_port_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_master = 1'b1, cfg_wide = 1'b1, cfg_alt = 1'b0, cfg_idle_hi = 1'b0;
  logic [3:0] cfg_div = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, ovr_clr = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic busy, rbf, ovr, sclk_out, sclk_oe, mo_out, mo_oe, mi_out, mi_oe;
  logic sclk_in = 1'b0, sel_n = 1'b1, mo_in = 1'b0, mi_in = 1'b0;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [15:0] exp_buf = '0;
  // bench peer model (slave side when the port is master)
  logic [15:0] peer_sh = '0, peer_rx = '0;
  int peer_edges = 0, hp_cnt = 0;
  bit hp_bad = 0, phase0 = 0, sclk_prev = 0;

  always #4 clk = ~clk;

  mw_port #(.DATA_W(16), .DIV_W(4)) uut (
    .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_wide(cfg_wide),
    .cfg_alt(cfg_alt), .cfg_idle_hi(cfg_idle_hi), .cfg_div(cfg_div),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .ovr_clr(ovr_clr), .busy(busy), .rbf(rbf), .ovr(ovr),
    .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sclk_in(sclk_in), .sel_n(sel_n),
    .mo_out(mo_out), .mo_oe(mo_oe), .mo_in(mo_in),
    .mi_out(mi_out), .mi_oe(mi_oe), .mi_in(mi_in)
  );

  function automatic logic fmsb(input logic [15:0] v, input bit w);
    return w ? v[15] : v[7];
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      summary();
      $finish;
    end
  end

  // Peer: reacts to sclk_out away from the active edge.
  always @(negedge clk) begin
    if (cfg_master && !rst) begin
      hp_cnt++;
      if (sclk_out != sclk_prev) begin
        if (peer_edges != 0 && hp_cnt != int'(cfg_div) + 1) hp_bad = 1;
        hp_cnt = 0;
        peer_edges++;
        if (sclk_out ^ cfg_alt) peer_rx = {peer_rx[14:0], mo_out};
        else if (phase0) begin
          peer_sh = peer_sh << 1;
          mi_in = fmsb(peer_sh, cfg_wide);
        end else begin
          mi_in = fmsb(peer_sh, cfg_wide);
          peer_sh = peer_sh << 1;
        end
      end
      sclk_prev = sclk_out;
    end
  end

  task automatic host_write(input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic host_read();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic m_run(input bit alt, input bit idle, input bit wide, input int div,
                       input logic [15:0] tx, input logic [15:0] pw);
    @(negedge clk);
    cfg_master = 1'b1; cfg_alt = alt; cfg_idle_hi = idle; cfg_wide = wide; cfg_div = 4'(div);
    repeat (3) @(negedge clk);
    peer_sh = pw; peer_rx = '0; peer_edges = 0; hp_cnt = 0; hp_bad = 0;
    sclk_prev = sclk_out; phase0 = (idle == alt);
    mi_in = phase0 ? fmsb(pw, wide) : 1'b0;
    host_write(tx);
    check(busy == 1'b1, "R10 busy after write", 16'(busy), 16'h1);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check((wide ? peer_rx : {8'h00, peer_rx[7:0]}) == (wide ? tx : {8'h00, tx[7:0]}),
          wide ? "R2/R4 sent word" : "R3/R4 sent byte", peer_rx, tx);
    check(peer_edges == (wide ? 32 : 16), "R5 edge count", 16'(peer_edges), wide ? 16'd32 : 16'd16);
    check(!hp_bad, "R5 half period", 16'(hp_bad), 16'h0);
    check(sclk_out == idle, "R10 idle level", 16'(sclk_out), 16'(idle));
  endtask

  task automatic s_run(input bit alt, input bit idle, input bit wide,
                       input logic [15:0] tx, input logic [15:0] mw, output logic [15:0] srx);
    logic [15:0] msh;
    bit ph0;
    @(negedge clk);
    cfg_master = 1'b0; cfg_alt = alt; cfg_idle_hi = idle; cfg_wide = wide;
    sclk_in = idle; sel_n = 1'b1;
    repeat (4) @(negedge clk);
    host_write(tx);
    ph0 = (idle == alt); msh = mw; srx = '0;
    mo_in = ph0 ? fmsb(mw, wide) : 1'b0;
    sel_n = 1'b0;
    repeat (5) @(negedge clk);
    check(busy && mi_oe, "R9 selected slave drives", {busy, mi_oe}, 16'h3);
    for (int e = 0; e < (wide ? 32 : 16); e++) begin
      sclk_in = ~sclk_in;
      if (sclk_in ^ alt) srx = {srx[14:0], mi_out};
      else if (ph0) begin msh = msh << 1; mo_in = fmsb(msh, wide); end
      else begin mo_in = fmsb(msh, wide); msh = msh << 1; end
      repeat (6) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    sel_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [15:0] tx, pw, srx, m1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !rbf && !ovr, "R1 flags", {busy, rbf, ovr}, 16'h0);
    check(rd_data == 16'h0, "R1 buffer", rd_data, 16'h0);
    check(sclk_out == 1'b0, "R1 idle clock", 16'(sclk_out), 16'h0);

    // Master sweep over edge mode, idle level, width and divider.
    for (int m = 0; m < 8; m++) begin
      for (int d = 0; d < 4; d += (d == 1 ? 2 : 1)) begin
        tx = 16'(16'h1357 * (m + 1) + 16'h0F1 * d) ^ 16'hA5C3;
        pw = 16'(16'h2B4D * (d + 3) - 16'h0713 * m);
        m_run(m[0], m[1], m[2], d, tx, pw);
        exp_buf = m[2] ? pw : {exp_buf[15:8], pw[7:0]};
        check(rbf == 1'b1, "R7 full after frame", 16'(rbf), 16'h1);
        check(rd_data == exp_buf, m[2] ? "R2 received word" : "R3 byte keeps high", rd_data, exp_buf);
        host_read();
        check(rbf == 1'b0, "R7 read clears", 16'(rbf), 16'h0);
      end
    end

    // Double buffering and overrun in master mode.
    m_run(0, 0, 1, 1, 16'hC0DE, 16'h1111);
    check(rbf && rd_data == 16'h1111, "R7 first frame", rd_data, 16'h1111);
    m_run(0, 0, 1, 1, 16'hBEEF, 16'h2222);
    check(rd_data == 16'h1111 && rbf, "R6/R7 buffer held", rd_data, 16'h1111);
    check(ovr == 1'b0, "R8 no overrun yet", 16'(ovr), 16'h0);
    m_run(0, 0, 1, 1, 16'hF00D, 16'h3333);
    check(ovr == 1'b1, "R8 overrun set", 16'(ovr), 16'h1);
    host_read();
    check(rbf == 1'b0, "R7 cleared on read", 16'(rbf), 16'h0);
    @(negedge clk);
    check(rbf && rd_data == 16'h3333, "R7 waiting frame moves", rd_data, 16'h3333);
    check(ovr == 1'b1, "R8 overrun sticky", 16'(ovr), 16'h1);
    @(negedge clk); ovr_clr = 1'b1;
    @(negedge clk); ovr_clr = 1'b0;
    check(ovr == 1'b0, "R8 overrun cleared", 16'(ovr), 16'h0);
    host_read();
    exp_buf = 16'h3333;

    // Slave sweep.
    for (int m = 0; m < 8; m++) begin
      tx = 16'(16'h6A39 + 16'h1111 * m);
      pw = 16'(16'h9C5E - 16'h0B07 * m);
      s_run(m[0], m[1], m[2], tx, pw, srx);
      exp_buf = m[2] ? pw : {exp_buf[15:8], pw[7:0]};
      check((m[2] ? srx : {8'h00, srx[7:0]}) == (m[2] ? tx : {8'h00, tx[7:0]}),
            "R9/R4 slave sent", srx, tx);
      check(rbf && rd_data == exp_buf, m[2] ? "R9 slave word" : "R3 slave byte", rd_data, exp_buf);
      host_read();
    end

    // Slave: frames while buffer full never raise overrun.
    s_run(0, 0, 1, 16'h0001, 16'h4444, srx);
    s_run(0, 0, 1, 16'h0002, 16'h5555, srx);
    s_run(0, 0, 1, 16'h0003, 16'h6666, srx);
    m1 = rd_data;
    check(m1 == 16'h4444 && ovr == 1'b0, "R9 no slave overrun", {15'h0, ovr}, 16'h0);
    host_read();
    @(negedge clk);
    check(rbf && rd_data == 16'h6666, "R7 slave waiting frame", rd_data, 16'h6666);
    host_read();

    summary();
    $finish;
  end
endmodule